// File: doc/BRIEF.md
# Reference Loss Auto Power-Down Monitor

This block watches a reference clock from a free-running monitor clock and decides whether the reference is still fast enough to drive the PLL. The reference passes through a two-flop synchronizer. Its rising edges are counted over fixed windows of `WIN_LEN` monitor cycles. A window whose count falls below the active threshold is a failed window. After a failed window the block raises a shutdown request, which stops the outputs, and it also powers the PLL down.

The monitor only runs while its enable bit is set and no output pair takes its clock straight from the reference. An output pair does that when its 3-bit source code is `3'b000`. A separate PLL power-down bit serves fanout-only use and always reaches the PLL control, whatever the monitor state. With the monitor off and the PLL powered down, the reference may stop at DC and no shutdown follows.

A threshold input of zero selects a default floor. The default equals the 10 MHz minimum PLL input rate, expressed in edges per window for the given monitor-clock rate. Shutdown is released only after two passing windows in a row.

Top module: `ref_loss_pdn`

## Requirements
- R1: Rising edges of `ref_clk_i`, seen through a two-flop synchronizer, are counted in back-to-back windows of `WIN_LEN` monitor cycles. The windows are aligned to reset release. The decision for a window takes effect at the edge that ends it (every `WIN_LEN` cycles after reset).
- R2: While the monitor is active, a window whose edge count is below the active threshold sets `shutdown_o` high at the end of that window. `shutdown_o` changes at no other time, except when the monitor turns off.
- R3: When `thresh_i` is zero, the threshold is `FLOOR_MHZ*WIN_LEN/MON_MHZ` edges (6 with defaults, the 10 MHz floor). A nonzero value is used as given.
- R4: The first window end after reset, and the first one after the monitor becomes active, never raises `shutdown_o`.
- R5: Once shut down, `shutdown_o` falls only after two consecutive passing windows. A failing window between them restarts the count.
- R6: With `apd_en_i` low the monitor is inactive. `shutdown_o` drops in the cycle after that and stays low.
- R7: If any pair source field in `pair_src_i` equals `3'b000` (pair p occupies bits `[3p+2:3p]`), the monitor is inactive, just as for R6.
- R8: `pll_pd_o` is high whenever `pll_off_i` or `shutdown_o` is high, and low otherwise.
- R9: With `apd_en_i` low and `pll_off_i` high, a reference held at DC gives `shutdown_o` low and `pll_pd_o` high.
- R10: While `rst_ni` is low, and after it is released, `shutdown_o` starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running monitor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock being watched (asynchronous) |
| apd_en_i | input | 1 | Auto power-down enable from the active personality |
| pll_off_i | input | 1 | PLL power-down for fanout-only use |
| pair_src_i | input | NUM_PAIRS*SRC_W | Per-pair output source codes, pair p at bits [SRC_W*p+SRC_W-1:SRC_W*p] |
| thresh_i | input | CNT_W | Minimum edges per window; zero selects the default floor |
| shutdown_o | output | 1 | Device shutdown request |
| pll_pd_o | output | 1 | PLL power-down control |

## Verification
The hardest state to reach from the ports is the release hysteresis. The bench must show that one passing window after a failure is not enough, and that a failing window placed between two passing ones restarts the count. A reference that starts or stops mid-window gives partial counts that are hard to predict. The bench therefore keeps the reference at a constant 8 edges per window and moves `thresh_i` between 12 and 4 at mid-window points. This makes each window pass or fail exactly as intended. Activation mid-window is driven the same way, so that the ignored partial window falls at a known boundary.

// File: rtl/ref_loss_pkg.sv
package ref_loss_pkg;
  typedef enum logic [1:0] {
    MON_ARM  = 2'd0,
    MON_RUN  = 2'd1,
    MON_FAIL = 2'd2
  } mon_state_e;

  localparam logic [2:0] SRC_DIRECT_REF = 3'b000;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/ref_window_count.sv
module ref_window_count #(
  parameter int WIN_LEN = 64,
  parameter int CNT_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             win_end_o,
  output logic             win_ok_o
);
  localparam int                 TMR_W    = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [TMR_W-1:0]   TMR_LAST = TMR_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0]   CNT_MAX  = '1;

  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;

  // timer free-runs from reset so window edges stay aligned to it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmr_q <= '0;
    else if (win_end_o) tmr_q <= '0;
    else                tmr_q <= tmr_q + 1'b1;
  end

  assign win_end_o = (tmr_q == TMR_LAST);
  assign cnt_inc   = (rise_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  // an edge in the last cycle still belongs to the closing window
  assign win_ok_o  = (cnt_inc >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/ref_loss_fsm.sv
module ref_loss_fsm
  import ref_loss_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic win_end_i,
  input  logic win_ok_i,
  output logic shutdown_o
);
  mon_state_e state_q;
  logic       good_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_ARM;
      good_q  <= 1'b0;
    end else if (!active_i) begin
      state_q <= MON_ARM;
      good_q  <= 1'b0;
    end else if (win_end_i) begin
      unique case (state_q)
        MON_ARM: begin
          state_q <= MON_RUN;
          good_q  <= 1'b0;
        end
        MON_RUN: begin
          if (!win_ok_i) state_q <= MON_FAIL;
          good_q <= 1'b0;
        end
        MON_FAIL: begin
          if (!win_ok_i) begin
            good_q <= 1'b0;
          end else if (good_q) begin
            state_q <= MON_RUN;
            good_q  <= 1'b0;
          end else begin
            good_q <= 1'b1;
          end
        end
        default: begin
          state_q <= MON_ARM;
          good_q  <= 1'b0;
        end
      endcase
    end
  end

  assign shutdown_o = (state_q == MON_FAIL);
endmodule

// File: rtl/ref_loss_pdn.sv
module ref_loss_pdn
  import ref_loss_pkg::*;
#(
  parameter int  NUM_PAIRS   = 6,
  parameter int  SRC_W       = 3,
  parameter int  WIN_LEN     = 64,
  parameter int  MON_MHZ     = 100,
  parameter int  FLOOR_MHZ   = 10,
  parameter int  SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(WIN_LEN + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ref_clk_i,
  input  logic                       apd_en_i,
  input  logic                       pll_off_i,
  input  logic [NUM_PAIRS*SRC_W-1:0] pair_src_i,
  input  logic [CNT_W-1:0]           thresh_i,
  output logic                       shutdown_o,
  output logic                       pll_pd_o
);
  localparam int               DEF_THR   = FLOOR_MHZ * WIN_LEN / MON_MHZ;
  localparam logic [CNT_W-1:0] DEF_THR_V = CNT_W'(DEF_THR);

  logic [NUM_PAIRS-1:0] pair_direct;
  logic                 mon_active;
  logic                 ref_rise;
  logic                 win_end, win_ok;
  logic [CNT_W-1:0]     thr_eff;

  generate
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign pair_direct[p] =
        (pair_src_i[SRC_W*p +: SRC_W] == SRC_W'(SRC_DIRECT_REF));
    end
  endgenerate

  assign mon_active = apd_en_i & ~|pair_direct;
  assign thr_eff    = (thresh_i == '0) ? DEF_THR_V : thresh_i;

  ref_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_clk_i),
    .rise_o (ref_rise)
  );

  ref_window_count #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) i_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (ref_rise),
    .thresh_i  (thr_eff),
    .win_end_o (win_end),
    .win_ok_o  (win_ok)
  );

  ref_loss_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (mon_active),
    .win_end_i  (win_end),
    .win_ok_i   (win_ok),
    .shutdown_o (shutdown_o)
  );

  assign pll_pd_o = pll_off_i | shutdown_o;
endmodule

// File: rtl/ref_loss_pdn_chk.sv
module ref_loss_pdn_chk #(
  parameter int NUM_PAIRS = 6,
  parameter int SRC_W     = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       apd_en_i,
  input logic                       pll_off_i,
  input logic [NUM_PAIRS*SRC_W-1:0] pair_src_i,
  input logic                       win_end_i,
  input logic                       win_ok_i,
  input logic                       shutdown_o,
  input logic                       pll_pd_o
);
  logic any_direct, active, seen_end_q, ok_prev_q;

  always_comb begin
    any_direct = 1'b0;
    for (int p = 0; p < NUM_PAIRS; p++)
      if (pair_src_i[SRC_W*p +: SRC_W] == '0) any_direct = 1'b1;
  end
  assign active = apd_en_i & ~any_direct;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_end_q <= 1'b0;
      ok_prev_q  <= 1'b0;
    end else if (!active) begin
      seen_end_q <= 1'b0;
      ok_prev_q  <= 1'b0;
    end else if (win_end_i) begin
      seen_end_q <= 1'b1;
      ok_prev_q  <= win_ok_i;
    end
  end

  // R6 R7
  a_r6_inactive_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !shutdown_o);

  a_r8_pd_follows_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_off_i |-> pll_pd_o);

  a_r8_pd_follows_sd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> pll_pd_o);

  a_r8_pd_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_off_i && !shutdown_o) |-> !pll_pd_o);

  a_r2_change_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shutdown_o) |-> ($past(win_end_i) || !$past(active)));

  a_r4_first_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(seen_end_q));

  a_r5_two_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(shutdown_o) && $past(active)) |-> ($past(win_ok_i) && $past(ok_prev_q)));
endmodule

bind ref_loss_pdn ref_loss_pdn_chk #(.NUM_PAIRS(NUM_PAIRS), .SRC_W(SRC_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .apd_en_i   (apd_en_i),
  .pll_off_i  (pll_off_i),
  .pair_src_i (pair_src_i),
  .win_end_i  (win_end),
  .win_ok_i   (win_ok),
  .shutdown_o (shutdown_o),
  .pll_pd_o   (pll_pd_o)
);

// File: tb/test_ref_loss_pdn.sv
module test_ref_loss_pdn;
  localparam int NP = 6;
  localparam int SW = 3;
  localparam int CW = 7;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_clk = 1'b0;
  logic          apd_en = 1'b1;
  logic          pll_off = 1'b0;
  logic [NP*SW-1:0] pair_src;
  logic [CW-1:0] thresh = '0;
  logic          shutdown, pll_pd;
  int            ref_half = 0;
  int            cyc = 0;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  ref_loss_pdn i_ref_loss_pdn (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ref_clk_i  (ref_clk),
    .apd_en_i   (apd_en),
    .pll_off_i  (pll_off),
    .pair_src_i (pair_src),
    .thresh_i   (thresh),
    .shutdown_o (shutdown),
    .pll_pd_o   (pll_pd)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always begin
    if (ref_half == 0) @(negedge clk);
    else begin
      repeat (ref_half) @(negedge clk);
      ref_clk = ~ref_clk;
    end
  end

  // {apd, pll_off, direct pair (7 = none), ref half-period, exp_sd, exp_pd}
  localparam logic [11:0] VECS [NV] = '{
    {1'b1, 1'b0, 3'd7, 5'd0,  1'b1, 1'b1},
    {1'b0, 1'b1, 3'd7, 5'd0,  1'b0, 1'b1},
    {1'b1, 1'b0, 3'd3, 5'd0,  1'b0, 1'b0},
    {1'b1, 1'b1, 3'd5, 5'd0,  1'b0, 1'b1},
    {1'b1, 1'b0, 3'd7, 5'd4,  1'b0, 1'b0},
    {1'b0, 1'b0, 3'd7, 5'd0,  1'b0, 1'b0},
    {1'b1, 1'b1, 3'd7, 5'd0,  1'b1, 1'b1},
    {1'b1, 1'b0, 3'd0, 5'd0,  1'b0, 1'b0},
    {1'b1, 1'b0, 3'd7, 5'd16, 1'b1, 1'b1}
  };
  localparam string TAGS [NV] = '{"R2", "R9", "R7", "R8", "R3", "R6", "R8", "R7", "R3"};

  function automatic logic [NP*SW-1:0] mk_src(int direct);
    logic [NP*SW-1:0] v;
    for (int p = 0; p < NP; p++) v[SW*p +: SW] = (p == direct) ? 3'b000 : 3'b010;
    return v;
  endfunction

  task automatic go_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic check(string tag, logic exp_sd, logic exp_pd);
    checks++;
    if (shutdown !== exp_sd || pll_pd !== exp_pd) begin
      errors++;
      $display("FAIL %s at cycle %0d: shutdown=%b pll_pd=%b expected shutdown=%b pll_pd=%b",
               tag, cyc, shutdown, pll_pd, exp_sd, exp_pd);
    end
  endtask

  initial begin
    pair_src = mk_src(7);
    repeat (3) @(negedge clk);
    check("R10", 1'b0, 1'b0);
    rst_n = 1'b1;
    // window ends at posedges 64k; checks sit mid-window
    go_to(96);   check("R4", 1'b0, 1'b0);
    go_to(130);  ref_half = 4;
    go_to(160);  check("R2", 1'b1, 1'b1);
    go_to(224);  check("R5", 1'b1, 1'b1);
    go_to(288);  check("R1", 1'b0, 1'b0);
    thresh = 7'd12;
    go_to(352);  check("R2", 1'b1, 1'b1);
    thresh = 7'd4;
    go_to(416);  check("R5", 1'b1, 1'b1);
    thresh = 7'd12;
    go_to(480);  check("R5", 1'b1, 1'b1);
    thresh = 7'd4;
    go_to(544);  check("R5", 1'b1, 1'b1);
    go_to(608);  check("R5", 1'b0, 1'b0);
    thresh = 7'd12;
    go_to(672);  check("R2", 1'b1, 1'b1);
    apd_en = 1'b0;
    go_to(674);  check("R6", 1'b0, 1'b0);
    apd_en = 1'b1;
    go_to(720);  check("R4", 1'b0, 1'b0);
    go_to(800);  check("R2", 1'b1, 1'b1);
    pair_src = mk_src(2);
    go_to(802);  check("R7", 1'b0, 1'b0);
    go_to(900);  check("R7", 1'b0, 1'b0);
    pair_src = mk_src(7);
    thresh = '0;
    go_to(928);
    for (int i = 0; i < NV; i++) begin
      apd_en   = VECS[i][11];
      pll_off  = VECS[i][10];
      pair_src = mk_src(int'(VECS[i][9:7]));
      ref_half = int'(VECS[i][6:2]);
      go_to(928 + 256 * (i + 1));
      check(TAGS[i], VECS[i][1], VECS[i][0]);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule